// File: doc/BRIEF.md
# Digitally Filtered PLL Lock Detector

This block reports whether a phase-locked loop has settled, using the two edge streams that feed its phase detector: the reference divider edge and the feedback divider edge. Each stream is first thinned to one edge in 64. The block then times the gap between the leading edges of the two thinned streams in cycles of a fast sampling clock. It compares that gap against a tolerance window, which stands in for a short analog delay of roughly ten nanoseconds. The window is set at run time as a cycle count.

A filter turns the pass and miss results into a lock flag. The flag rises only after a run of consecutive passes. It falls on the first miss. If one thinned edge arrives and its partner does not follow within twice the window, the comparison counts as a miss. An enable input holds the flag low without disturbing the filter. Both input streams are assumed to be synchronous to the sampling clock.

Top module: `pll_lock_filter`

## Requirements
- R1: Only every 64th rising edge of each input starts or completes a comparison: the 1st after reset, then the 65th, 129th and so on. Skew between the two inputs on any other edge has no effect on `lock_out`.
- R2: The error is the number of sampling-clock cycles between the two thinned leading edges. It passes only when it is strictly below `win_cycles`. An error equal to `win_cycles` is a miss.
- R3: Either input may lead, and the same window applies in both directions.
- R4: `lock_out` rises after 4 consecutive passing comparisons. Further passes keep it high.
- R5: A single miss clears `lock_out` at once, and the pass count restarts from zero.
- R6: If one thinned edge is not followed by the other within 2 × `win_cycles` cycles, the comparison is a miss and the block waits for a fresh pair.
- R7: While `ld_en` is 0, `lock_out` is 0. The filter keeps running, so raising `ld_en` again shows the current lock state.
- R8: Reset clears both divide-by-64 counters, the pass count and the lock flag.
- R9: The window follows the `win_cycles` input. A wider window accepts errors that a narrower one rejects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference divider output |
| fb_in | input | 1 | Feedback divider output |
| win_cycles | input | WIN_W | Tolerance window in sampling cycles |
| ld_en | input | 1 | Lock indication enable; 0 forces the output low |
| lock_out | output | 1 | Filtered lock flag |

## Verification
The bench probes the window boundary with errors of exactly one window, for two window settings. A design that treated equality as a pass would raise lock there. Skew is placed on an edge that the divider should ignore. Skew is also placed on the 54th edge after a reset taken partway through a divider count. A divider that counts every edge, or that keeps its count across reset, would then report a miss and fail to lock. Other stimuli cover a partner edge arriving far too late, a miss inside a run of passes, and toggling the enable while locked. These catch designs that hang waiting for an edge, that keep a stale pass count, or that lose filter state while the output is held low.

// File: rtl/lock_det_pkg.sv
package lock_det_pkg;

    typedef enum logic [1:0] {
        CMP_IDLE     = 2'd0,
        CMP_WAIT_FB  = 2'd1,
        CMP_WAIT_REF = 2'd2
    } cmp_state_e;

endpackage

// File: rtl/edge_prescaler.sv
module edge_prescaler #(
    parameter int PRESCALE = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic div_edge
);
    localparam int PRE_W = $clog2(PRESCALE);

    typedef struct packed {
        logic             prev;
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d      = st_q;
        st_d.prev = sig_in;
        rise      = sig_in & ~st_q.prev;
        div_edge  = rise && (st_q.cnt == '0);
        if (rise) begin
            if (st_q.cnt == PRE_W'(PRESCALE - 1)) st_d.cnt = '0;
            else                                  st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: after a counted leading edge the next edge is not a leading edge
    a_r1_div_advance: assert property (@(posedge clk) disable iff (!rst_n)
        div_edge |=> (st_q.cnt != '0));

endmodule

// File: rtl/phase_window_cmp.sv
module phase_window_cmp
    import lock_det_pkg::*;
#(
    parameter int WIN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_ev,
    input  logic             fb_ev,
    input  logic [WIN_W-1:0] win_cycles,
    output logic             pass_o,
    output logic             miss_o
);
    localparam int CNT_W = WIN_W + 1;

    typedef struct packed {
        cmp_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             pass;
        logic             miss;
    } cmp_t;

    cmp_t st_d, st_q;
    logic [CNT_W-1:0] win_x;
    logic [CNT_W-1:0] tmo;
    logic             partner;
    logic             in_win;

    always_comb begin
        win_x   = {1'b0, win_cycles};
        tmo     = {win_cycles, 1'b0};
        in_win  = st_q.cnt < win_x;
        partner = (st_q.state == CMP_WAIT_FB) ? fb_ev : ref_ev;

        st_d      = st_q;
        st_d.pass = 1'b0;
        st_d.miss = 1'b0;
        unique case (st_q.state)
            CMP_IDLE: begin
                if (ref_ev && fb_ev) begin
                    st_d.pass = (win_cycles != '0);
                    st_d.miss = (win_cycles == '0);
                end else if (ref_ev) begin
                    st_d.state = CMP_WAIT_FB;
                    st_d.cnt   = CNT_W'(1);
                end else if (fb_ev) begin
                    st_d.state = CMP_WAIT_REF;
                    st_d.cnt   = CNT_W'(1);
                end
            end
            CMP_WAIT_FB, CMP_WAIT_REF: begin
                if (partner) begin
                    st_d.pass  = in_win;
                    st_d.miss  = !in_win;
                    st_d.state = CMP_IDLE;
                    st_d.cnt   = '0;
                end else if (st_q.cnt >= tmo) begin
                    st_d.miss  = 1'b1;
                    st_d.state = CMP_IDLE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pass_o = st_q.pass;
    assign miss_o = st_q.miss;

    // R2: a comparison yields at most one verdict
    a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && miss_o));

    // R6: a wait that reaches the timeout without its partner ends in a miss
    a_r6_timeout_miss: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.state != CMP_IDLE) && !partner && (st_q.cnt >= tmo))
        |=> (miss_o && st_q.state == CMP_IDLE));

endmodule

// File: rtl/lock_run_filter.sv
module lock_run_filter #(
    parameter int LOCK_RUN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pass_i,
    input  logic miss_i,
    output logic lock_o
);
    localparam int RUN_W = $clog2(LOCK_RUN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             lock;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (miss_i) begin
            st_d.run  = '0;
            st_d.lock = 1'b0;
        end else if (pass_i) begin
            if (st_q.run < RUN_W'(LOCK_RUN)) st_d.run = st_q.run + 1'b1;
            if (st_q.run >= RUN_W'(LOCK_RUN - 1)) st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.lock;

    // R5: any miss drops lock on the next edge
    a_r5_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> !lock_o);

    // R4: lock only ever rises on the edge after a pass
    a_r4_rise_after_pass: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(pass_i));

endmodule

// File: rtl/pll_lock_filter.sv
module pll_lock_filter #(
    parameter int PRESCALE = 64,
    parameter int WIN_W    = 6,
    parameter int LOCK_RUN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [WIN_W-1:0] win_cycles,
    input  logic             ld_en,
    output logic             lock_out
);
    logic ref_ev, fb_ev, pass_w, miss_w, lock_w;
    logic [1:0] in_bus, ev_bus;

    assign in_bus = {fb_in, ref_in};

    for (genvar g = 0; g < 2; g++) begin : g_pre
        edge_prescaler #(.PRESCALE(PRESCALE)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .sig_in   (in_bus[g]),
            .div_edge (ev_bus[g])
        );
    end

    assign ref_ev = ev_bus[0];
    assign fb_ev  = ev_bus[1];

    phase_window_cmp #(.WIN_W(WIN_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_ev     (ref_ev),
        .fb_ev      (fb_ev),
        .win_cycles (win_cycles),
        .pass_o     (pass_w),
        .miss_o     (miss_w)
    );

    lock_run_filter #(.LOCK_RUN(LOCK_RUN)) u_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .pass_i (pass_w),
        .miss_i (miss_w),
        .lock_o (lock_w)
    );

    assign lock_out = lock_w & ld_en;

endmodule

// File: tb/tb_pll_lock_filter.sv
module tb_pll_lock_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       fb_in = 1'b0;
    logic [5:0] win_cycles = 6'd4;
    logic       ld_en = 1'b1;
    logic       lock_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pll_lock_filter dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .win_cycles(win_cycles), .ld_en(ld_en), .lock_out(lock_out)
    );

    typedef struct packed {
        logic [7:0] ra;
        logic [7:0] fa;
        logic       exp_lock;
    } vec_t;

    // window = 4: error = fa - ra (either sign), pass when |error| < 4
    localparam vec_t VECS [14] = '{
        '{8'd5, 8'd5,  1'b0},   // R2 error 0
        '{8'd5, 8'd7,  1'b0},   // R2 error 2
        '{8'd7, 8'd5,  1'b0},   // R3 feedback leads
        '{8'd5, 8'd8,  1'b1},   // R4 fourth pass, error 3
        '{8'd5, 8'd9,  1'b0},   // R2 error equals window, R5 drop
        '{8'd5, 8'd5,  1'b0},
        '{8'd5, 8'd6,  1'b0},
        '{8'd5, 8'd5,  1'b0},
        '{8'd8, 8'd5,  1'b1},   // R3 R4 feedback leads by 3
        '{8'd5, 8'd35, 1'b0},   // R6 partner far too late
        '{8'd5, 8'd5,  1'b0},
        '{8'd5, 8'd5,  1'b0},
        '{8'd5, 8'd5,  1'b0},
        '{8'd5, 8'd5,  1'b1}    // R4 lock after restart
    };

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: lock_out=%0b expected %0b", req, got, exp);
        end
    endtask

    task automatic slot(input int ra, input int fa, input int len);
        for (int c = 0; c < len; c++) begin
            ref_in = (c == ra);
            fb_in  = (c == fa);
            @(negedge clk);
        end
        ref_in = 1'b0;
        fb_in  = 1'b0;
    endtask

    // one full divide-by-64 period; slot 'bad' carries a large skew
    task automatic period(input int ra, input int fa, input int bad, input int first);
        for (int s = first; s < 64; s++) begin
            if (s == 0)        slot(ra, fa, 40);
            else if (s == bad) slot(1, 30, 40);
            else               slot(0, 0, 2);
        end
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(lock_out, 1'b0, "R8 reset state");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 14; i++) begin
            period(int'(VECS[i].ra), int'(VECS[i].fa), -1, 0);
            check(lock_out, VECS[i].exp_lock, $sformatf("R2 R4 R5 vector %0d", i));
        end

        // R7: enable low forces output low, filter state kept
        ld_en = 1'b0;
        #1;
        check(lock_out, 1'b0, "R7 enable low");
        period(5, 5, -1, 0);
        check(lock_out, 1'b0, "R7 enable low during pass");
        ld_en = 1'b1;
        #1;
        check(lock_out, 1'b1, "R7 re-enable restores lock");

        // R1: skew on a non-leading edge is ignored
        period(5, 5, 10, 0);
        check(lock_out, 1'b1, "R1 skew on ignored edge");

        // R8: reset mid-count clears dividers and lock
        slot(5, 5, 40);
        for (int s = 1; s < 11; s++) slot(0, 0, 2);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check(lock_out, 1'b0, "R8 reset clears lock");
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 3; p++) period(5, 5, 53, 0);
        check(lock_out, 1'b0, "R8 three passes after reset");
        period(5, 5, 53, 0);
        check(lock_out, 1'b1, "R1 R8 divider restarted by reset");

        // R9: wider window accepts error 7, rejects error 8
        win_cycles = 6'd8;
        period(5, 13, -1, 0);
        check(lock_out, 1'b0, "R9 R2 error equals window 8");
        for (int p = 0; p < 3; p++) period(5, 12, -1, 0);
        check(lock_out, 1'b0, "R9 three passes at error 7");
        period(12, 5, -1, 0);
        check(lock_out, 1'b1, "R9 R3 lock at error 7");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule